// File: doc/BRIEF.md
# SM3 Message Schedule Stage-One Unit

This unit performs the first half of the SM3 message expansion for four new schedule words in one operation. It takes three 128-bit operands: an accumulator operand that is both read and replaced, a first source and a second source. Each operand holds four 32-bit words, and the unit combines them through a fixed word mapping, a rotate-and-XOR network and the P1 permutation. The 128-bit result is meant to be written back over the accumulator operand.

The unit sits in an execution pipeline as a single registered stage. A valid strobe goes in with the operands, and the result appears one clock later with its own valid strobe. When no operation is presented, the output register keeps its last result. The unit has no status or flag outputs.

Top module: `sm3_sched1_unit`

## Requirements
- R1: Every 128-bit operand and the result hold four 32-bit words, with word n in bits 32n+31 down to 32n.
- R2: For word positions 0, 1 and 2, the value fed to P1 is accumulator word k XOR second-source word k XOR (first-source word k rotated left circularly by 15).
- R3: For word position 3, the value fed to P1 is accumulator word 3 XOR second-source word 3 only, and first-source word 3 has no effect on any part of the result.
- R4: Each result word is P1(t) = t XOR (t rotated left by 15) XOR (t rotated left by 23), all rotations being 32-bit circular shifts.
- R5: valid_o is high in exactly those cycles whose preceding clock edge sampled valid_i high, so back-to-back operations give back-to-back results.
- R6: While rst_ni is low, valid_o is 0 and result_o is all zeros.
- R7: A clock edge that samples valid_i low leaves result_o unchanged, whatever the operand inputs carry.
- R8: Operands of all ones give a result whose words 0 to 2 are all ones and whose word 3 is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands are valid this cycle |
| acc_i | input | 128 | Accumulator operand, read and later replaced by the result |
| srca_i | input | 128 | First source operand; word 3 unused |
| srcb_i | input | 128 | Second source operand |
| valid_o | output | 1 | result_o holds a fresh result |
| result_o | output | 128 | Four expanded schedule words |

## Verification
Every result is due at the first rising edge after the operands are presented with valid_i high, so the bench drives inputs on a falling edge and compares result_o and valid_o on the very next falling edge, one register later. For streaming it presents a new operation on every falling edge and checks each previous one in the same half-cycle slot. For hold checks, valid_i is dropped and the operands are changed, and the output is compared two falling edges later against the last accepted result. The single-bit sweeps over all 384 operand bits make the lane-3 omission and the dead first-source word visible at the output.

// File: rtl/sm3s1_pkg.sv
package sm3s1_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LANES    = 4;
  localparam int unsigned MIX_ROT  = 15;
  localparam int unsigned P1_ROT_A = 15;
  localparam int unsigned P1_ROT_B = 23;

  // lanes below the top one carry the rotated first-source term
  function automatic bit lane_has_rot(int unsigned lane, int unsigned lanes);
    return lane < lanes - 1;
  endfunction
endpackage

// File: rtl/sm3s1_rol.sv
module sm3s1_rol #(
  parameter int unsigned W = 32,
  parameter int unsigned R = 15
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned SH = R % W;

  generate
    if (SH == 0) begin : g_pass
      assign y_o = x_i;
    end else begin : g_rot
      assign y_o = {x_i[W-1-SH:0], x_i[W-1:W-SH]};
    end
  endgenerate
endmodule

// File: rtl/sm3s1_mix.sv
module sm3s1_mix #(
  parameter int unsigned W   = 32,
  parameter int unsigned ROT = 15
) (
  input  logic [W-1:0] acc_word_i,
  input  logic [W-1:0] srcb_word_i,
  input  logic [W-1:0] srca_word_i,
  output logic [W-1:0] t_o
);
  logic [W-1:0] srca_rot;

  sm3s1_rol #(.W(W), .R(ROT)) u_rol (
    .x_i(srca_word_i),
    .y_o(srca_rot)
  );

  assign t_o = acc_word_i ^ srcb_word_i ^ srca_rot;
endmodule

// File: rtl/sm3s1_perm.sv
module sm3s1_perm #(
  parameter int unsigned W  = 32,
  parameter int unsigned RA = 15,
  parameter int unsigned RB = 23
) (
  input  logic [W-1:0] t_i,
  output logic [W-1:0] p_o
);
  logic [W-1:0] rot_a, rot_b;

  sm3s1_rol #(.W(W), .R(RA)) u_rol_a (.x_i(t_i), .y_o(rot_a));
  sm3s1_rol #(.W(W), .R(RB)) u_rol_b (.x_i(t_i), .y_o(rot_b));

  assign p_o = t_i ^ rot_a ^ rot_b;
endmodule

// File: rtl/sm3_sched1_unit.sv
module sm3_sched1_unit #(
  parameter int unsigned WORD_W   = sm3s1_pkg::WORD_W,
  parameter int unsigned LANES    = sm3s1_pkg::LANES,
  parameter int unsigned MIX_ROT  = sm3s1_pkg::MIX_ROT,
  parameter int unsigned P1_ROT_A = sm3s1_pkg::P1_ROT_A,
  parameter int unsigned P1_ROT_B = sm3s1_pkg::P1_ROT_B,
  localparam int unsigned OP_W    = WORD_W * LANES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] acc_i,
  input  logic [OP_W-1:0] srca_i,
  input  logic [OP_W-1:0] srcb_i,
  output logic            valid_o,
  output logic [OP_W-1:0] result_o
);
  logic [WORD_W-1:0] t_w [LANES];
  logic [OP_W-1:0]   res_d;
  logic [OP_W-1:0]   res_q;
  logic              valid_q;
  logic              unused_srca_top;

  // top first-source word never enters the network
  assign unused_srca_top = ^srca_i[OP_W-1 -: WORD_W];

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (sm3s1_pkg::lane_has_rot(k, LANES)) begin : g_rot
        sm3s1_mix #(.W(WORD_W), .ROT(MIX_ROT)) u_mix (
          .acc_word_i (acc_i [k*WORD_W +: WORD_W]),
          .srcb_word_i(srcb_i[k*WORD_W +: WORD_W]),
          .srca_word_i(srca_i[k*WORD_W +: WORD_W]),
          .t_o        (t_w[k])
        );
      end else begin : g_plain
        assign t_w[k] = acc_i[k*WORD_W +: WORD_W] ^ srcb_i[k*WORD_W +: WORD_W];
      end

      sm3s1_perm #(.W(WORD_W), .RA(P1_ROT_A), .RB(P1_ROT_B)) u_perm (
        .t_i(t_w[k]),
        .p_o(res_d[k*WORD_W +: WORD_W])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
endmodule

// File: rtl/sm3_sched1_chk.sv
module sm3_sched1_chk #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned LANES    = 4,
  parameter int unsigned MIX_ROT  = 15,
  parameter int unsigned P1_ROT_A = 15,
  parameter int unsigned P1_ROT_B = 23,
  localparam int unsigned OP_W    = WORD_W * LANES
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [OP_W-1:0] acc_i,
  input logic [OP_W-1:0] srca_i,
  input logic [OP_W-1:0] srcb_i,
  input logic            valid_o,
  input logic [OP_W-1:0] result_o
);
  localparam int unsigned TOP = (LANES - 1) * WORD_W;

  function automatic logic [WORD_W-1:0] rl(logic [WORD_W-1:0] x, int unsigned n);
    int unsigned s;
    s = n % WORD_W;
    if (s == 0) return x;
    return (x << s) | (x >> (WORD_W - s));
  endfunction

  function automatic logic [WORD_W-1:0] p1(logic [WORD_W-1:0] t);
    return t ^ rl(t, P1_ROT_A) ^ rl(t, P1_ROT_B);
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R6: assert (!valid_o && result_o == '0);
    end
  end

  assert_valid_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  assert_lane0_mix_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> result_o[WORD_W-1:0] ==
      p1($past(acc_i[WORD_W-1:0]) ^ $past(srcb_i[WORD_W-1:0]) ^
         rl($past(srca_i[WORD_W-1:0]), MIX_ROT)));

  assert_top_lane_plain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> result_o[TOP +: WORD_W] ==
      p1($past(acc_i[TOP +: WORD_W]) ^ $past(srcb_i[TOP +: WORD_W])));
endmodule

bind sm3_sched1_unit sm3_sched1_chk #(
  .WORD_W  (WORD_W),
  .LANES   (LANES),
  .MIX_ROT (MIX_ROT),
  .P1_ROT_A(P1_ROT_A),
  .P1_ROT_B(P1_ROT_B)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .acc_i   (acc_i),
  .srca_i  (srca_i),
  .srcb_i  (srcb_i),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/test_sm3_sched1_unit.sv
module test_sm3_sched1_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] acc_i = '0, srca_i = '0, srcb_i = '0;
  logic         valid_o;
  logic [127:0] result_o;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4ns clk_i = ~clk_i;

  sm3_sched1_unit i_sm3_sched1_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .acc_i(acc_i), .srca_i(srca_i), .srcb_i(srcb_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] p1f(logic [31:0] t);
    return t ^ rl(t, 15) ^ rl(t, 23);
  endfunction

  // model from R1..R4
  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] s1, logic [127:0] s2);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] t;
      t = a[32*k +: 32] ^ s2[32*k +: 32];
      if (k < 3) t = t ^ rl(s1[32*k +: 32], 15);
      r[32*k +: 32] = p1f(t);
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  endtask

  task automatic one_op(string req, logic [127:0] a, logic [127:0] s1, logic [127:0] s2,
                        logic [127:0] exp);
    @(negedge clk_i);
    acc_i = a; srca_i = s1; srcb_i = s2; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " valid"}, {127'd0, valid_o}, 128'd1);
    check(req, result_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [127:0] last, a, s1, s2;
    repeat (3) @(negedge clk_i);
    // R6
    check("R6 valid in reset", {127'd0, valid_o}, 128'd0);
    check("R6 result in reset", result_o, '0);
    rst_ni = 1'b1;

    one_op("R1 zeros", '0, '0, '0, '0);
    one_op("R8 all ones", '1, '1, '1, 128'h00000000_ffffffff_ffffffff_ffffffff);
    one_op("R4 top lane single bit", '0, '0, 128'h1 << 96, 128'h00808001 << 96);
    one_op("R2 lane0 rotated bit", '0, 128'h1, '0, 128'h40008040);
    one_op("R3 unused first-source word", '0, 128'h1 << 96, '0, '0);
    one_op("R3 unused word beside data", 128'h1234, '1, 128'h77 << 100,
           model(128'h1234, '1, 128'h77 << 100));

    // single-bit sweeps over every operand bit (R1 R2 R3 R4)
    for (int i = 0; i < 128; i++) begin
      one_op("R2 acc bit", 128'h1 << i, '0, '0, model(128'h1 << i, '0, '0));
      one_op("R4 srcb bit", '0, '0, 128'h1 << i, model('0, '0, 128'h1 << i));
      one_op("R3 srca bit", '0, 128'h1 << i, '0, model('0, 128'h1 << i, '0));
    end

    // random operands
    for (int n = 0; n < 300; n++) begin
      a  = {$urandom, $urandom, $urandom, $urandom};
      s1 = {$urandom, $urandom, $urandom, $urandom};
      s2 = {$urandom, $urandom, $urandom, $urandom};
      one_op("R2 random", a, s1, s2, model(a, s1, s2));
    end

    // R5 back-to-back stream
    @(negedge clk_i);
    for (int n = 0; n < 20; n++) begin
      logic [127:0] e;
      a  = {$urandom, $urandom, $urandom, $urandom};
      s1 = {$urandom, $urandom, $urandom, $urandom};
      s2 = {$urandom, $urandom, $urandom, $urandom};
      e = model(a, s1, s2);
      acc_i = a; srca_i = s1; srcb_i = s2; valid_i = 1'b1;
      @(negedge clk_i);
      check("R5 stream valid", {127'd0, valid_o}, 128'd1);
      check("R5 stream result", result_o, e);
    end
    valid_i = 1'b0;

    // R7 hold while idle
    last = result_o;
    acc_i = '1; srca_i = 128'h5a5a; srcb_i = 128'hdead_beef;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R5 idle valid low", {127'd0, valid_o}, 128'd0);
    check("R7 hold while idle", result_o, last);

    // R6 asynchronous reset mid-run
    one_op("R2 before reset", '1, '0, '0, model('1, '0, '0));
    #1ns rst_ni = 1'b0;
    #1ns;
    check("R6 async clear result", result_o, '0);
    check("R6 async clear valid", {127'd0, valid_o}, 128'd0);
    finish_run();
  end
endmodule